// File: doc/BRIEF.md
# Branch and Subroutine Sequencer

This block owns the program counter and the stack pointer of a small CPU with a 16-bit address space. Each cycle in which it is idle it may take one control-flow operation from the decoder. The operation can be a plain step to the following instruction, a PC-relative branch, an absolute jump, a subroutine call with an absolute or a relative target, or a return. A relative branch is taken or not according to a 4-bit condition code evaluated against the carry, zero, negative and overflow flags. The operation also carries the length of the current instruction, so the block can form the address of the following instruction.

Calls and returns move a two-byte return address through a byte-wide stack memory port, one byte per cycle. The stack grows toward lower addresses. The stack pointer always addresses the most recently written byte. While a call or return is in progress, `busy` is high and new operations are ignored. The PC takes its new value on the same clock edge at which the last stack byte is moved, and that is the edge at which `busy` falls.

Top module: `pc_flow_ctrl`

## Requirements
- R1: After reset, `pc` is 16'h0400, `sp` is 16'h0100, and `busy`, `mem_we` and `mem_re` are low.
- R2: An accepted op_kind 0 (step), and any unused op_kind code 6 or 7, sets `pc` to `pc + instr_len` at the next clock edge.
- R3: For op_kind 1 (branch), the taken target is `pc + instr_len` plus `rel_off` sign-extended to 16 bits: 00..7F moves forward and 80..FF moves backward. For example, a next address of 000F with offset F7 gives 0006.
- R4: The cond_code values decide a branch as follows. 0 is always taken. 1 is taken when C=0 and 2 when C=1. 3 is taken when Z=1 and 4 when Z=0. 5 is taken when N=1 and 6 when N=0. 7 is taken when Z=0 and N equals V. 8 is taken when Z=1 or N differs from V. Codes 9 to 15 are never taken.
- R5: A branch that is not taken sets `pc` to `pc + instr_len`.
- R6: op_kind 2 (jump) loads `abs_target` into `pc` at the next edge.
- R7: op_kind 3 (call) writes the low byte of `pc + instr_len` to address `sp-1` in the first cycle after acceptance, then the high byte to `sp-2` in the second cycle. `sp` falls by one per written byte, and `pc` becomes `abs_target` at the end of the second cycle.
- R8: op_kind 4 (relative call) behaves as R7, but the target is computed as in R3.
- R9: op_kind 5 (return) reads address `sp` in the first cycle and `sp+1` in the second. `pc` becomes {first byte, second byte}, and `sp` rises by two.
- R10: `busy` is high for exactly the two stack cycles of a call or return. Operations offered while `busy` is high are ignored, and `pc` does not change before the final stack cycle.
- R11: All PC and stack address arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | An operation is offered this cycle |
| op_kind | input | 3 | 0 step, 1 branch, 2 jump, 3 call, 4 relative call, 5 return |
| cond_code | input | 4 | Branch condition select (see R4) |
| rel_off | input | 8 | Signed relative offset |
| abs_target | input | 16 | Absolute jump or call target |
| instr_len | input | 3 | Length in bytes of the current instruction |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| mem_rdata | input | 8 | Stack read data, valid in the same cycle as the address |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| busy | output | 1 | Call or return in progress |
| mem_we | output | 1 | Stack write strobe |
| mem_re | output | 1 | Stack read strobe |
| mem_addr | output | 16 | Stack byte address |
| mem_wdata | output | 8 | Stack write data |

## Verification
A corrupted return-address latch or byte order shows up on `mem_wdata` one or two cycles after a call is accepted, well before the return that would reload it. A wrong stack pointer appears on `mem_addr` in the very first stack cycle, and on the `sp` port immediately after. An error in condition evaluation or offset sign extension shows on `pc` one edge after the branch is accepted. The bench sweeps every condition code against all sixteen flag patterns so that a single wrong table entry cannot hide.

// File: rtl/pcf_pkg.sv
package pcf_pkg;

  typedef enum logic [2:0] {
    OP_STEP     = 3'd0,
    OP_BRANCH   = 3'd1,
    OP_JUMP     = 3'd2,
    OP_CALL     = 3'd3,
    OP_CALL_REL = 3'd4,
    OP_RETURN   = 3'd5
  } op_kind_e;

  typedef enum logic [3:0] {
    CC_ALWAYS    = 4'd0,
    CC_CARRY_CLR = 4'd1,
    CC_CARRY_SET = 4'd2,
    CC_EQUAL     = 4'd3,
    CC_NOT_EQUAL = 4'd4,
    CC_MINUS     = 4'd5,
    CC_PLUS      = 4'd6,
    CC_GREATER   = 4'd7,
    CC_LESS_EQ   = 4'd8
  } cond_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PUSH_LO = 3'd1,
    ST_PUSH_HI = 3'd2,
    ST_POP_HI  = 3'd3,
    ST_POP_LO  = 3'd4
  } seq_state_e;

endpackage

// File: rtl/pcf_cond_eval.sv
module pcf_cond_eval
  import pcf_pkg::*;
(
  input  logic [3:0] cond_code,
  input  logic       flag_n,
  input  logic       flag_z,
  input  logic       flag_v,
  input  logic       flag_c,
  output logic       taken
);

  logic sign_mismatch;

  always_comb begin
    sign_mismatch = flag_n ^ flag_v;
    case (cond_e'(cond_code))
      CC_ALWAYS:    taken = 1'b1;
      CC_CARRY_CLR: taken = ~flag_c;
      CC_CARRY_SET: taken = flag_c;
      CC_EQUAL:     taken = flag_z;
      CC_NOT_EQUAL: taken = ~flag_z;
      CC_MINUS:     taken = flag_n;
      CC_PLUS:      taken = ~flag_n;
      CC_GREATER:   taken = ~flag_z & ~sign_mismatch;
      CC_LESS_EQ:   taken = flag_z | sign_mismatch;
      default:      taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/pcf_target_gen.sv
module pcf_target_gen #(
  parameter int AW    = 16,
  parameter int OFF_W = 8,
  parameter int LEN_W = 3
) (
  input  logic [AW-1:0]    pc_cur,
  input  logic [LEN_W-1:0] instr_len,
  input  logic [OFF_W-1:0] rel_off,
  output logic [AW-1:0]    next_pc,
  output logic [AW-1:0]    rel_pc
);

  localparam int LEN_PAD = AW - LEN_W;
  localparam int OFF_PAD = AW - OFF_W;

  logic [AW-1:0] off_ext;

  always_comb begin
    next_pc = pc_cur + {{LEN_PAD{1'b0}}, instr_len};
    off_ext = {{OFF_PAD{rel_off[OFF_W-1]}}, rel_off};
    rel_pc  = next_pc + off_ext;
  end

endmodule

// File: rtl/pcf_stack_port.sv
module pcf_stack_port
  import pcf_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  seq_state_e    state,
  input  logic [AW-1:0] sp_cur,
  input  logic [AW-1:0] ret_addr,
  output logic          mem_we,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);

  localparam logic [AW-1:0] ONE = AW'(1);

  always_comb begin
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_addr  = sp_cur;
    mem_wdata = ret_addr[DW-1:0];
    case (state)
      ST_PUSH_LO: begin
        mem_we    = 1'b1;
        mem_addr  = sp_cur - ONE;
        mem_wdata = ret_addr[DW-1:0];
      end
      ST_PUSH_HI: begin
        mem_we    = 1'b1;
        mem_addr  = sp_cur - ONE;
        mem_wdata = ret_addr[AW-1:DW];
      end
      ST_POP_HI, ST_POP_LO: begin
        mem_re   = 1'b1;
        mem_addr = sp_cur;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pc_flow_ctrl.sv
module pc_flow_ctrl
  import pcf_pkg::*;
#(
  parameter int              AW       = 16,
  parameter int              DW       = 8,
  parameter int              LEN_W    = 3,
  parameter logic [AW-1:0]   PC_RESET = 16'h0400,
  parameter logic [AW-1:0]   SP_RESET = 16'h0100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [2:0]       op_kind,
  input  logic [3:0]       cond_code,
  input  logic [DW-1:0]    rel_off,
  input  logic [AW-1:0]    abs_target,
  input  logic [LEN_W-1:0] instr_len,
  input  logic             flag_n,
  input  logic             flag_z,
  input  logic             flag_v,
  input  logic             flag_c,
  input  logic [DW-1:0]    mem_rdata,
  output logic [AW-1:0]    pc,
  output logic [AW-1:0]    sp,
  output logic             busy,
  output logic             mem_we,
  output logic             mem_re,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata
);

  localparam logic [AW-1:0] ONE = AW'(1);

  // reset synchronizer: asserts asynchronously, releases on the clock
  logic [1:0] rst_pipe;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  seq_state_e    state_q, state_d;
  logic [AW-1:0] pc_q, pc_d;
  logic [AW-1:0] sp_q, sp_d;
  logic [AW-1:0] ret_q, ret_d;
  logic [AW-1:0] tgt_q, tgt_d;
  logic [DW-1:0] hi_q, hi_d;
  logic          pc_en, sp_en, ret_en, hi_en;

  logic [AW-1:0] next_pc, rel_pc;
  logic          taken;

  pcf_cond_eval u_cond (
    .cond_code (cond_code),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .flag_v    (flag_v),
    .flag_c    (flag_c),
    .taken     (taken)
  );

  pcf_target_gen #(.AW(AW), .OFF_W(DW), .LEN_W(LEN_W)) u_tgt (
    .pc_cur    (pc_q),
    .instr_len (instr_len),
    .rel_off   (rel_off),
    .next_pc   (next_pc),
    .rel_pc    (rel_pc)
  );

  pcf_stack_port #(.AW(AW), .DW(DW)) u_stk (
    .state     (state_q),
    .sp_cur    (sp_q),
    .ret_addr  (ret_q),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    pc_d    = pc_q;
    sp_d    = sp_q;
    ret_d   = ret_q;
    tgt_d   = tgt_q;
    hi_d    = hi_q;
    pc_en   = 1'b0;
    sp_en   = 1'b0;
    ret_en  = 1'b0;
    hi_en   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (op_valid) begin
          case (op_kind_e'(op_kind))
            OP_BRANCH: begin
              pc_d  = taken ? rel_pc : next_pc;
              pc_en = 1'b1;
            end
            OP_JUMP: begin
              pc_d  = abs_target;
              pc_en = 1'b1;
            end
            OP_CALL: begin
              ret_d   = next_pc;
              tgt_d   = abs_target;
              ret_en  = 1'b1;
              state_d = ST_PUSH_LO;
            end
            OP_CALL_REL: begin
              ret_d   = next_pc;
              tgt_d   = rel_pc;
              ret_en  = 1'b1;
              state_d = ST_PUSH_LO;
            end
            OP_RETURN: begin
              state_d = ST_POP_HI;
            end
            default: begin
              pc_d  = next_pc;
              pc_en = 1'b1;
            end
          endcase
        end
      end
      ST_PUSH_LO: begin
        sp_d    = sp_q - ONE;
        sp_en   = 1'b1;
        state_d = ST_PUSH_HI;
      end
      ST_PUSH_HI: begin
        sp_d    = sp_q - ONE;
        sp_en   = 1'b1;
        pc_d    = tgt_q;
        pc_en   = 1'b1;
        state_d = ST_IDLE;
      end
      ST_POP_HI: begin
        hi_d    = mem_rdata;
        hi_en   = 1'b1;
        sp_d    = sp_q + ONE;
        sp_en   = 1'b1;
        state_d = ST_POP_LO;
      end
      ST_POP_LO: begin
        pc_d    = {hi_q, mem_rdata};
        pc_en   = 1'b1;
        sp_d    = sp_q + ONE;
        sp_en   = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      pc_q    <= PC_RESET;
      sp_q    <= SP_RESET;
      ret_q   <= '0;
      tgt_q   <= '0;
      hi_q    <= '0;
    end else begin
      state_q <= state_d;
      if (pc_en)  pc_q <= pc_d;
      if (sp_en)  sp_q <= sp_d;
      if (ret_en) begin
        ret_q <= ret_d;
        tgt_q <= tgt_d;
      end
      if (hi_en)  hi_q <= hi_d;
    end
  end

  assign pc   = pc_q;
  assign sp   = sp_q;
  assign busy = (state_q != ST_IDLE);

  // assertions
  a_r7_push_addr: assert property (@(posedge clk) disable iff (!rst_n_s)
    mem_we |-> (mem_addr == sp_q - ONE));

  a_r7_push_sp_dec: assert property (@(posedge clk) disable iff (!rst_n_s)
    mem_we |=> (sp_q == $past(sp_q) - ONE));

  a_r9_pop_sp_inc: assert property (@(posedge clk) disable iff (!rst_n_s)
    mem_re |=> (sp_q == $past(sp_q) + ONE));

  a_r9_pop_addr: assert property (@(posedge clk) disable iff (!rst_n_s)
    mem_re |-> (mem_addr == sp_q));

  a_r10_pc_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(busy) |=> $stable(pc_q));

  a_r10_mem_only_busy: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_we || mem_re) |-> busy);

  a_r10_rw_exclusive: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(mem_we && mem_re));

endmodule

// File: tb/tb_pc_flow_ctrl.sv
`timescale 1ns/1ps
module tb_pc_flow_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [2:0]  op_kind;
  logic [3:0]  cond_code;
  logic [7:0]  rel_off;
  logic [15:0] abs_target;
  logic [2:0]  instr_len;
  logic        flag_n, flag_z, flag_v, flag_c;
  logic [7:0]  mem_rdata;
  logic [15:0] pc, sp, mem_addr;
  logic        busy, mem_we, mem_re;
  logic [7:0]  mem_wdata;

  logic [7:0]  stk [0:255];
  int          n_tests = 0;
  int          n_fail  = 0;
  bit          done    = 1'b0;

  always #10 clk = ~clk;

  pc_flow_ctrl dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .cond_code(cond_code), .rel_off(rel_off), .abs_target(abs_target),
    .instr_len(instr_len), .flag_n(flag_n), .flag_z(flag_z),
    .flag_v(flag_v), .flag_c(flag_c), .mem_rdata(mem_rdata),
    .pc(pc), .sp(sp), .busy(busy), .mem_we(mem_we), .mem_re(mem_re),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always @(posedge clk) if (mem_we) stk[mem_addr[7:0]] <= mem_wdata;
  assign mem_rdata = stk[mem_addr[7:0]];

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    check(act == exp, req, act, exp);
  endtask

  function automatic bit model_taken(input int code, input bit n, input bit z,
                                     input bit v, input bit c);
    case (code)
      0: return 1'b1;
      1: return !c;
      2: return c;
      3: return z;
      4: return !z;
      5: return n;
      6: return !n;
      7: return !z && (n == v);
      8: return z || (n != v);
      default: return 1'b0;
    endcase
  endfunction

  // present one op for one cycle; returns at the negedge after acceptance
  task automatic issue(input logic [2:0] kind, input logic [3:0] cc,
                       input logic [7:0] off, input logic [15:0] tgt,
                       input logic [2:0] len);
    @(negedge clk);
    op_valid = 1'b1; op_kind = kind; cond_code = cc;
    rel_off = off; abs_target = tgt; instr_len = len;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic set_pc(input logic [15:0] a);
    issue(3'd2, 4'd0, 8'h00, a, 3'd0);
  endtask

  task automatic t_reset;
    chk("R1 pc", pc, 16'h0400);
    chk("R1 sp", sp, 16'h0100);
    chk("R1 busy/we/re", {busy, mem_we, mem_re}, 3'b000);
  endtask

  task automatic t_step;
    issue(3'd0, 4'd0, 8'h00, 16'h0, 3'd3);
    chk("R2 step len3", pc, 16'h0403);
    issue(3'd6, 4'd0, 8'h00, 16'h0, 3'd1);
    chk("R2 unused kind 6 steps", pc, 16'h0404);
  endtask

  task automatic t_jump;
    issue(3'd2, 4'd0, 8'h00, 16'hBEEF, 3'd2);
    chk("R6 jump", pc, 16'hBEEF);
  endtask

  task automatic t_relative;
    set_pc(16'h000D);
    issue(3'd1, 4'd0, 8'hF7, 16'h0, 3'd2);
    chk("R3 backward 000F+F7", pc, 16'h0006);
    issue(3'd1, 4'd0, 8'h7F, 16'h0, 3'd2);
    chk("R3 forward +7F", pc, 16'h0087);
  endtask

  task automatic t_conditions;
    for (int code = 0; code < 16; code++) begin
      for (int f = 0; f < 16; f++) begin
        bit exp_t;
        set_pc(16'h1000);
        {flag_n, flag_z, flag_v, flag_c} = 4'(f);
        exp_t = model_taken(code, f[3], f[2], f[1], f[0]);
        issue(3'd1, 4'(code), 8'h10, 16'h0, 3'd2);
        if (exp_t) chk($sformatf("R4 code %0d flags %h taken", code, f), pc, 16'h1012);
        else       chk($sformatf("R5 code %0d flags %h not taken", code, f), pc, 16'h1002);
      end
    end
    {flag_n, flag_z, flag_v, flag_c} = 4'b0000;
  endtask

  task automatic t_call_abs;
    set_pc(16'h1230);
    issue(3'd3, 4'd0, 8'h00, 16'h2000, 3'd3);
    chk("R7 c1 busy/we", {busy, mem_we, mem_re}, 3'b110);
    chk("R7 c1 addr", mem_addr, 16'h00FF);
    chk("R7 c1 low byte", mem_wdata, 8'h33);
    chk("R10 pc held c1", pc, 16'h1230);
    @(negedge clk);
    chk("R7 c2 busy/we", {busy, mem_we}, 2'b11);
    chk("R7 c2 addr", mem_addr, 16'h00FE);
    chk("R7 c2 high byte", mem_wdata, 8'h12);
    chk("R7 c2 sp", sp, 16'h00FF);
    chk("R10 pc held c2", pc, 16'h1230);
    @(negedge clk);
    chk("R10 busy low after", busy, 1'b0);
    chk("R7 pc target", pc, 16'h2000);
    chk("R7 sp after", sp, 16'h00FE);
    chk("R7 mem FF", stk[8'hFF], 8'h33);
    chk("R7 mem FE", stk[8'hFE], 8'h12);
  endtask

  task automatic t_call_rel;
    issue(3'd4, 4'd0, 8'h80, 16'hFFFF, 3'd2);
    chk("R8 c1 addr", mem_addr, 16'h00FD);
    chk("R8 c1 low byte", mem_wdata, 8'h02);
    @(negedge clk);
    chk("R8 c2 high byte", mem_wdata, 8'h20);
    @(negedge clk);
    chk("R8 pc 2002-80", pc, 16'h1F82);
    chk("R8 sp", sp, 16'h00FC);
  endtask

  task automatic t_return;
    issue(3'd5, 4'd0, 8'h00, 16'h0, 3'd1);
    chk("R9 c1 re/busy", {busy, mem_re, mem_we}, 3'b110);
    chk("R9 c1 addr", mem_addr, 16'h00FC);
    chk("R10 pc held ret", pc, 16'h1F82);
    @(negedge clk);
    chk("R9 c2 addr", mem_addr, 16'h00FD);
    @(negedge clk);
    chk("R9 pc inner", pc, 16'h2002);
    chk("R9 sp inner", sp, 16'h00FE);
    issue(3'd5, 4'd0, 8'h00, 16'h0, 3'd1);
    repeat (2) @(negedge clk);
    chk("R9 pc outer", pc, 16'h1233);
    chk("R9 sp outer", sp, 16'h0100);
  endtask

  task automatic t_busy_ignore;
    set_pc(16'h0500);
    @(negedge clk);
    op_valid = 1'b1; op_kind = 3'd3; abs_target = 16'h3000; instr_len = 3'd1;
    @(negedge clk);
    op_kind = 3'd2; abs_target = 16'hDEAD;
    chk("R10 busy c1", busy, 1'b1);
    @(negedge clk);
    chk("R10 pc ignores op c2", pc, 16'h0500);
    @(negedge clk);
    op_valid = 1'b0;
    chk("R10 pc after ignored ops", pc, 16'h3000);
    chk("R10 sp after ignored ops", sp, 16'h00FE);
    issue(3'd5, 4'd0, 8'h00, 16'h0, 3'd1);
    repeat (2) @(negedge clk);
    chk("R10 return after ignore", pc, 16'h0501);
  endtask

  task automatic t_wrap;
    set_pc(16'hFFFE);
    issue(3'd0, 4'd0, 8'h00, 16'h0, 3'd4);
    chk("R11 step wrap", pc, 16'h0002);
    set_pc(16'h0000);
    issue(3'd1, 4'd0, 8'hF0, 16'h0, 3'd2);
    chk("R11 branch wrap below 0", pc, 16'hFFF2);
  endtask

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_kind = 3'd0; cond_code = 4'd0;
    rel_off = 8'h00; abs_target = 16'h0; instr_len = 3'd0;
    {flag_n, flag_z, flag_v, flag_c} = 4'b0000;
    for (int i = 0; i < 256; i++) stk[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_step;
    t_jump;
    t_relative;
    t_conditions;
    t_call_abs;
    t_call_rel;
    t_return;
    t_busy_ignore;
    t_wrap;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule